// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Array

A single-port synchronous static RAM model that shares one data bus between reads and writes and lets the two alternate on consecutive clocks with no idle cycle between them. Commands (address, read/write, byte enables) are captured on the rising clock edge. The write data for a command is placed on the bus in the same bus slot where read data for a command issued on that edge would appear. In registered-output mode that slot is two cycles after the command. In flow-through mode it is one cycle after. The bus direction therefore never has to turn around between commands.

Because the storage is written late, a pipelined read can be issued while the previous write still waits for its data. The block detects that case and returns the pending data, byte by byte, merged with the stored word. Three chip enables select the device. An on-chip two-bit sequencer runs four-beat bursts in linear or interleaved order. An asynchronous output enable and an asynchronous sleep input can silence the bus at any time. Sleep also discards every command in flight.

Top module: `lwsram_core`

## Requirements
- R1: A new command is accepted at a rising edge only when `cs0_ni`=0, `cs1_i`=1 and `cs2_ni`=0 with `adv_i`=0; any other pattern is a deselect that writes nothing and drives no read data.
- R2: In flow-through mode (`pipe_mode_i`=0) a read captured at edge k drives its word on `dq_o` with `dq_oe_o`=1 in the cycle between edges k and k+1.
- R3: In registered-output mode (`pipe_mode_i`=1) a read captured at edge k drives its word in the cycle between edges k+1 and k+2, and the bus is not driven for it earlier.
- R4: Write data for a command captured at edge k is taken from `dq_i` at edge k+1 in flow-through mode and at edge k+2 in registered-output mode.
- R5: Byte enable `ben_i[j]`=1 writes bits [9j+8:9j] of the word; lanes whose enable is 0 keep their stored value.
- R6: Reads and writes may be issued on every consecutive edge in any mix; each read returns the data of all writes issued before it.
- R7: In registered-output mode a read issued on the edge after a write to the same address returns the pending write data in the enabled lanes and the stored data in the others.
- R8: With `adv_i`=1 after an accepted command, the low two address bits step as start+n mod 4 when `burst_ilv_i`=0, with the upper bits and the read/write type held and the chip enables ignored; `adv_i`=1 with no burst open is a deselect.
- R9: With `burst_ilv_i`=1 the n-th beat uses low address bits start XOR n.
- R10: `oe_ni`=1 forces `dq_oe_o`=0 at once, and taking it low inside a read slot enables the bus within the same cycle.
- R11: While `sleep_i`=1 the bus is not driven and commands are ignored; sleep across an edge discards every pending read and write.
- R12: During and after reset no read data is driven and no command is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pipe_mode_i | input | 1 | 1 = registered output, 0 = flow-through (static) |
| burst_ilv_i | input | 1 | 1 = interleaved burst order, 0 = linear (static) |
| sleep_i | input | 1 | Asynchronous sleep |
| cs0_ni | input | 1 | Chip enable, active low |
| cs1_i | input | 1 | Chip enable, active high |
| cs2_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | Continue the open burst |
| wr_i | input | 1 | 1 = write command, 0 = read |
| addr_i | input | AW | Word address |
| ben_i | input | NB | Byte-lane write enables |
| dq_i | input | NB*BW | Bus data into the block |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_o | output | NB*BW | Read data, zero when not driven |
| dq_oe_o | output | 1 | Bus driver enable |

## Verification
The bench aims at the bus slot arithmetic. A write taken one edge too early or too late in either mode leaves the wrong word behind, and that shows on a read issued immediately after. A pipelined read that follows a write to the same address with partial byte enables is the forwarding case: a design without forwarding returns the stale word, and one that merges the wrong lanes returns a mix. Both orders of burst are started away from low bits zero, so the wrap and the XOR pattern each show. A sleep held across an edge is checked to drop a pending write and a pending read rather than complete them late.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    localparam int unsigned LW_ADDR_W = 6;
    localparam int unsigned LW_BYTES  = 4;
    localparam int unsigned LW_BYTE_W = 9;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lw_op_e;

    // Low two address bits for beat number 'beat' of a burst opened at 'start'
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/lwsram_burst_seq.sv
module lwsram_burst_seq import lwsram_pkg::*; #(
    parameter int unsigned AW = LW_ADDR_W,
    parameter int unsigned NB = LW_BYTES
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sleep_i,
    input  logic          sel_ok_i,
    input  logic          adv_i,
    input  logic          wr_i,
    input  logic          ilv_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NB-1:0] ben_i,
    output lw_op_e        op_o,
    output logic [AW-1:0] addr_o,
    output logic [NB-1:0] ben_o
);

    typedef struct packed {
        logic          act;
        logic          wr;
        logic [1:0]    start;
        logic [1:0]    beat;
        lw_op_e        op;
        logic [AW-1:0] addr;
        logic [NB-1:0] ben;
    } seq_st_t;

    seq_st_t    seq_d, seq_q;
    logic [1:0] beat_nx;

    always_comb begin
        seq_d    = seq_q;
        seq_d.op = OP_NONE;
        beat_nx  = seq_q.beat + 2'd1;
        if (sleep_i) begin
            seq_d.act = 1'b0;
        end else if (adv_i && seq_q.act) begin
            // continuation: chip enables and wr_i are not looked at
            seq_d.beat = beat_nx;
            seq_d.addr = {seq_q.addr[AW-1:2], burst_low(seq_q.start, beat_nx, ilv_i)};
            seq_d.op   = seq_q.wr ? OP_WRITE : OP_READ;
            seq_d.ben  = ben_i;
        end else if (!adv_i && sel_ok_i) begin
            seq_d.act   = 1'b1;
            seq_d.wr    = wr_i;
            seq_d.start = addr_i[1:0];
            seq_d.beat  = 2'd0;
            seq_d.addr  = addr_i;
            seq_d.op    = wr_i ? OP_WRITE : OP_READ;
            seq_d.ben   = ben_i;
        end else begin
            seq_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign op_o   = seq_q.op;
    assign addr_o = seq_q.addr;
    assign ben_o  = seq_q.ben;

    AST_BURST_UPPER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && adv_i && seq_q.act) |=> (seq_q.addr[AW-1:2] == $past(seq_q.addr[AW-1:2]))); // R8
    AST_BURST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && adv_i && seq_q.act) |=> (seq_q.beat == $past(seq_q.beat) + 2'd1)); // R9
    AST_CMD_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.op != OP_NONE) |-> $past(!sleep_i && ((adv_i && seq_q.act) || (!adv_i && sel_ok_i)))); // R1

endmodule

// File: rtl/lwsram_store.sv
module lwsram_store #(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 9,
    localparam int unsigned DW    = NB * BW,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [NB-1:0] wben_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    // one storage array per byte lane, so a lane enable gates only its own array
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_q [DEPTH];

        always_ff @(posedge clk_i) begin
            if (we_i && wben_i[b]) lane_q[waddr_i] <= wdata_i[b*BW +: BW];
        end

        assign rdata_o[b*BW +: BW] = lane_q[raddr_i];
    end

endmodule

// File: rtl/lwsram_fwd_merge.sv
module lwsram_fwd_merge #(
    parameter int unsigned NB = 4,
    parameter int unsigned BW = 9,
    localparam int unsigned DW = NB * BW
) (
    input  logic          hit_i,
    input  logic [NB-1:0] ben_i,
    input  logic [DW-1:0] bus_i,
    input  logic [DW-1:0] arr_i,
    output logic [DW-1:0] data_o
);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign data_o[b*BW +: BW] = (hit_i && ben_i[b]) ? bus_i[b*BW +: BW]
                                                        : arr_i[b*BW +: BW];
    end

endmodule

// File: rtl/lwsram_core.sv
module lwsram_core import lwsram_pkg::*; #(
    parameter int unsigned AW = LW_ADDR_W,
    parameter int unsigned NB = LW_BYTES,
    parameter int unsigned BW = LW_BYTE_W,
    localparam int unsigned DW = NB * BW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pipe_mode_i,
    input  logic          burst_ilv_i,
    input  logic          sleep_i,
    input  logic          cs0_ni,
    input  logic          cs1_i,
    input  logic          cs2_ni,
    input  logic          adv_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NB-1:0] ben_i,
    input  logic [DW-1:0] dq_i,
    input  logic          oe_ni,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o
);

    typedef struct packed {
        lw_op_e        s2_op;
        logic [AW-1:0] s2_addr;
        logic [NB-1:0] s2_ben;
        logic          out_vld;
        logic [DW-1:0] out_data;
    } core_st_t;

    core_st_t      core_d, core_q;
    logic          sel_ok;
    lw_op_e        s1_op;
    logic [AW-1:0] s1_addr;
    logic [NB-1:0] s1_ben;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] rd_merged;
    logic          fwd_hit;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [NB-1:0] mem_wben;
    logic          rd_slot;
    logic [DW-1:0] rd_word;

    assign sel_ok = !cs0_ni && cs1_i && !cs2_ni;

    // stage 1: command register with burst address generation
    lwsram_burst_seq #(.AW(AW), .NB(NB)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sleep_i  (sleep_i),
        .sel_ok_i (sel_ok),
        .adv_i    (adv_i),
        .wr_i     (wr_i),
        .ilv_i    (burst_ilv_i),
        .addr_i   (addr_i),
        .ben_i    (ben_i),
        .op_o     (s1_op),
        .addr_o   (s1_addr),
        .ben_o    (s1_ben)
    );

    lwsram_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
        .clk_i   (clk_i),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wben_i  (mem_wben),
        .wdata_i (dq_i),
        .raddr_i (s1_addr),
        .rdata_o (arr_rdata)
    );

    lwsram_fwd_merge #(.NB(NB), .BW(BW)) u_merge (
        .hit_i  (fwd_hit),
        .ben_i  (core_q.s2_ben),
        .bus_i  (dq_i),
        .arr_i  (arr_rdata),
        .data_o (rd_merged)
    );

    always_comb begin
        // a pipelined write waits one more cycle for its data; a read in
        // stage 1 to the same word must see that data from the bus
        fwd_hit   = pipe_mode_i && (s1_op == OP_READ) && (core_q.s2_op == OP_WRITE)
                    && (core_q.s2_addr == s1_addr);
        mem_we    = !sleep_i && (pipe_mode_i ? (core_q.s2_op == OP_WRITE) : (s1_op == OP_WRITE));
        mem_waddr = pipe_mode_i ? core_q.s2_addr : s1_addr;
        mem_wben  = pipe_mode_i ? core_q.s2_ben  : s1_ben;

        core_d = core_q;
        if (sleep_i) begin
            core_d.s2_op   = OP_NONE;
            core_d.out_vld = 1'b0;
        end else begin
            core_d.s2_op   = pipe_mode_i ? s1_op : OP_NONE;
            core_d.s2_addr = s1_addr;
            core_d.s2_ben  = s1_ben;
            core_d.out_vld = pipe_mode_i && (s1_op == OP_READ);
            if (pipe_mode_i && (s1_op == OP_READ)) core_d.out_data = rd_merged;
        end

        rd_slot = pipe_mode_i ? core_q.out_vld  : (s1_op == OP_READ);
        rd_word = pipe_mode_i ? core_q.out_data : arr_rdata;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    // output enable and sleep act on the driver without waiting for a clock
    assign dq_oe_o = rd_slot && !oe_ni && !sleep_i;
    assign dq_o    = dq_oe_o ? rd_word : '0;

    AST_PIPE_OUT_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_q.out_vld |-> $past((s1_op == OP_READ) && pipe_mode_i && !sleep_i)); // R3
    AST_PIPE_WRITE_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pipe_mode_i && mem_we) |-> $past(s1_op == OP_WRITE)); // R4
    AST_SLEEP_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(sleep_i) |-> ((s1_op == OP_NONE) && (core_q.s2_op == OP_NONE) && !core_q.out_vld)); // R11

endmodule

// File: tb/lwsram_core_tb_top.sv
module lwsram_core_tb_top;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    localparam logic [1:0] OP_I = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_W = 2'd2;
    localparam logic [1:0] OP_A = 2'd3;

    localparam logic [DW-1:0] D5  = 36'h1_2345_6789;
    localparam logic [DW-1:0] D6  = 36'h9_8765_4321;
    localparam logic [DW-1:0] E5  = 36'hA_BCDE_F012;
    localparam logic [DW-1:0] LO2 = 36'h0_0003_FFFF;   // byte lanes 0 and 1
    localparam logic [DW-1:0] MRG = (D5 & ~LO2) | (E5 & LO2);
    localparam logic [DW-1:0] F1  = 36'h3_1111_2222;
    localparam logic [DW-1:0] F2  = 36'h5_3333_4444;
    localparam logic [DW-1:0] F3  = 36'h7_5555_6666;
    localparam logic [DW-1:0] HI1 = 36'hF_F800_0000;   // byte lane 3
    localparam logic [DW-1:0] FM  = (F2 & ~HI1) | (F3 & HI1);
    localparam logic [DW-1:0] G20 = 36'h2_0202_0202;
    localparam logic [DW-1:0] H30 = 36'h3_0303_0303;
    localparam logic [DW-1:0] JNK = 36'hE_EEEE_EEEE;

    typedef struct packed {
        logic [2:0]    cs;      // {cs0_ni, cs1_i, cs2_ni}
        logic          adv;
        logic          wr;
        logic [AW-1:0] addr;
        logic [NB-1:0] ben;
        logic [DW-1:0] din;
        logic          oe_n;
        logic          slp;
        logic          exp_oe;
        logic [DW-1:0] exp_dq;
        logic [3:0]    req;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] op, input logic [AW-1:0] a,
                                input logic [NB-1:0] be, input logic [DW-1:0] din,
                                input logic eoe, input logic [DW-1:0] edq,
                                input logic [3:0] req);
        vec_t v;
        v.cs     = (op == OP_R || op == OP_W) ? 3'b010 : 3'b000;
        v.adv    = (op == OP_A);
        v.wr     = (op == OP_W);
        v.addr   = a;
        v.ben    = be;
        v.din    = din;
        v.oe_n   = 1'b0;
        v.slp    = 1'b0;
        v.exp_oe = eoe;
        v.exp_dq = edq;
        v.req    = req;
        return v;
    endfunction

    // registered-output traffic: double late write, read-write-read, forwarding
    localparam int NTBL = 11;
    localparam vec_t TBL [NTBL] = '{
        mk(OP_W, 6'd5, 4'hF,    '0,  1'b0, '0,  4'd4),   // R4
        mk(OP_W, 6'd6, 4'hF,    '0,  1'b0, '0,  4'd4),
        mk(OP_R, 6'd5, 4'h0,    D5,  1'b0, '0,  4'd4),
        mk(OP_R, 6'd6, 4'h0,    D6,  1'b0, '0,  4'd3),
        mk(OP_W, 6'd5, 4'b0011, '0,  1'b1, D5,  4'd3),   // R3
        mk(OP_R, 6'd5, 4'h0,    '0,  1'b1, D6,  4'd6),   // R6
        mk(OP_I, 6'd0, 4'h0,    E5,  1'b0, '0,  4'd3),
        mk(OP_I, 6'd0, 4'h0,    '0,  1'b1, MRG, 4'd7),   // R7
        mk(OP_R, 6'd5, 4'h0,    '0,  1'b0, '0,  4'd3),
        mk(OP_I, 6'd0, 4'h0,    '0,  1'b0, '0,  4'd3),
        mk(OP_I, 6'd0, 4'h0,    '0,  1'b1, MRG, 4'd5)    // R5
    };

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          burst_ilv = 1'b0;
    logic          sleep = 1'b0;
    logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic          adv = 1'b0, wr = 1'b0, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] ben = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    lwsram_core #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .pipe_mode_i (pipe_mode),
        .burst_ilv_i (burst_ilv),
        .sleep_i     (sleep),
        .cs0_ni      (cs0_n),
        .cs1_i       (cs1),
        .cs2_ni      (cs2_n),
        .adv_i       (adv),
        .wr_i        (wr),
        .addr_i      (addr),
        .ben_i       (ben),
        .dq_i        (dq_in),
        .oe_ni       (oe_n),
        .dq_o        (dq_out),
        .dq_oe_o     (dq_oe)
    );

    task automatic check_out(input logic eoe, input logic [DW-1:0] edq,
                             input logic [3:0] req, input string tag);
        n_chk++;
        if (dq_oe !== eoe || (eoe && dq_out !== edq)) begin
            n_fail++;
            $display("FAIL R%0d %s: oe=%0b dq=%h, expected oe=%0b dq=%h",
                     req, tag, dq_oe, dq_out, eoe, edq);
        end
    endtask

    task automatic drive(input vec_t v);
        {cs0_n, cs1, cs2_n} = v.cs;
        adv   = v.adv;
        wr    = v.wr;
        addr  = v.addr;
        ben   = v.ben;
        dq_in = v.din;
        oe_n  = v.oe_n;
        sleep = v.slp;
    endtask

    // one bus cycle: drive at start, sample at the falling edge, command taken at the end
    task automatic apply(input vec_t v, input string tag);
        drive(v);
        @(negedge clk);
        check_out(v.exp_oe, v.exp_dq, v.req, tag);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        drive(mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd12));
        rst_ni = 1'b0;
        @(negedge clk);
        check_out(1'b0, '0, 4'd12, "bus idle in reset");          // R12
        @(posedge clk);
        #1;
        rst_ni = 1'b1;
        @(negedge clk);
        check_out(1'b0, '0, 4'd12, "bus idle after reset");       // R12
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog: run still active, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        vec_t v;
        #1;
        do_reset();

        // ---- registered-output table (R3 R4 R5 R6 R7)
        for (int i = 0; i < NTBL; i++) apply(TBL[i], $sformatf("table %0d", i));

        // ---- asynchronous output enable, registered mode (R10)
        apply(mk(OP_R, 6'd6, '0, '0, 1'b0, '0, 4'd10), "oe read cmd");
        apply(mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd10), "oe gap");
        v = mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd10);
        v.oe_n = 1'b1;
        drive(v);
        @(negedge clk);
        check_out(1'b0, '0, 4'd10, "oe high blocks read slot");    // R10
        oe_n = 1'b0;
        #1;
        check_out(1'b1, D6, 4'd10, "oe low mid-cycle drives");      // R10
        @(posedge clk);
        #1;

        // ---- sleep, registered mode (R11)
        apply(mk(OP_W, 6'd30, 4'hF, '0,  1'b0, '0, 4'd11), "sleep preload");
        apply(mk(OP_I, '0,    '0,   '0,  1'b0, '0, 4'd11), "sleep preload gap");
        apply(mk(OP_R, 6'd30, '0,   H30, 1'b0, '0, 4'd11), "sleep read cmd");
        apply(mk(OP_I, '0,    '0,   '0,  1'b0, '0, 4'd11), "sleep gap");
        v = mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd11);
        v.slp = 1'b1;
        apply(v, "bus off while asleep");                          // R11
        apply(mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd11), "read discarded by sleep");
        apply(mk(OP_W, 6'd30, 4'hF, '0, 1'b0, '0, 4'd11), "write before sleep");
        apply(v, "sleep across write");
        apply(mk(OP_I, '0, '0, JNK, 1'b0, '0, 4'd11), "dropped write data");
        apply(mk(OP_R, 6'd30, '0, '0, 1'b0, '0, 4'd11), "read after dropped write");
        apply(mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd11), "gap");
        apply(mk(OP_I, '0, '0, '0, 1'b1, H30, 4'd11), "old word kept");  // R11
        v = mk(OP_R, 6'd30, '0, '0, 1'b0, '0, 4'd11);
        v.slp = 1'b1;
        apply(v, "read issued asleep");
        apply(mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd11), "gap");
        apply(mk(OP_I, '0, '0, '0, 1'b0, '0, 4'd11), "asleep read ignored");

        // ---- pending read cut by reset, then flow-through mode
        apply(mk(OP_R, 6'd6, '0, '0, 1'b0, '0, 4'd12), "read before reset");
        pipe_mode = 1'b0;
        do_reset();

        // single late write, read-write-read with no gap (R2 R4 R5 R6)
        apply(mk(OP_W, 6'd10, 4'hF,    '0, 1'b0, '0, 4'd4), "ft write a10");
        apply(mk(OP_R, 6'd10, '0,      F1, 1'b0, '0, 4'd4), "ft read a10");
        apply(mk(OP_W, 6'd11, 4'hF,    '0, 1'b1, F1, 4'd2), "ft read slot");     // R2
        apply(mk(OP_R, 6'd10, '0,      F2, 1'b0, '0, 4'd6), "ft write slot");
        apply(mk(OP_W, 6'd11, 4'b1000, '0, 1'b1, F1, 4'd6), "ft rwr read");      // R6
        apply(mk(OP_R, 6'd11, '0,      F3, 1'b0, '0, 4'd5), "ft lane write");
        apply(mk(OP_I, '0,    '0,      '0, 1'b1, FM, 4'd5), "ft lane merge");    // R5

        // chip enables (R1)
        apply(mk(OP_W, 6'd20, 4'hF, '0,  1'b0, '0, 4'd1), "cs preload");
        v = mk(OP_W, 6'd20, 4'hF, G20, 1'b0, '0, 4'd1);
        v.cs = 3'b110;
        apply(v, "cs0 inactive");
        v.cs = 3'b000;
        v.din = JNK;
        apply(v, "cs1 inactive");
        v.cs = 3'b011;
        apply(v, "cs2 inactive");
        v = mk(OP_R, 6'd20, '0, JNK, 1'b0, '0, 4'd1);
        v.cs = 3'b011;
        apply(v, "deselected read");
        apply(mk(OP_R, 6'd20, '0, '0,  1'b0, '0,  4'd1), "no drive for deselect");  // R1
        apply(mk(OP_I, '0,    '0, '0,  1'b1, G20, 4'd1), "deselected writes dropped"); // R1

        // bursts: preload 8..11 with a burst write, then read both orders (R8 R9)
        apply(mk(OP_W, 6'd8, 4'hF, '0, 1'b0, '0, 4'd8), "burst write start");
        for (int b = 1; b < 4; b++)
            apply(mk(OP_A, '0, 4'hF, DW'(256 + b - 1), 1'b0, '0, 4'd8), "burst write beat");
        apply(mk(OP_I, '0, '0, DW'(256 + 3), 1'b0, '0, 4'd8), "burst write tail");
        apply(mk(OP_R, 6'd10, '0, '0, 1'b0, '0,         4'd8), "linear start 10");
        apply(mk(OP_A, '0,    '0, '0, 1'b1, DW'(256+2), 4'd8), "linear beat 0");
        apply(mk(OP_A, '0,    '0, '0, 1'b1, DW'(256+3), 4'd8), "linear beat 1");
        apply(mk(OP_A, '0,    '0, '0, 1'b1, DW'(256+0), 4'd8), "linear wrap");    // R8
        apply(mk(OP_I, '0,    '0, '0, 1'b1, DW'(256+1), 4'd8), "linear beat 3");
        burst_ilv = 1'b1;
        apply(mk(OP_R, 6'd9, '0, '0, 1'b0, '0,         4'd9), "interleave start 9");
        apply(mk(OP_A, '0,   '0, '0, 1'b1, DW'(256+1), 4'd9), "interleave beat 0");
        apply(mk(OP_A, '0,   '0, '0, 1'b1, DW'(256+0), 4'd9), "interleave beat 1");
        apply(mk(OP_A, '0,   '0, '0, 1'b1, DW'(256+3), 4'd9), "interleave beat 2"); // R9
        apply(mk(OP_I, '0,   '0, '0, 1'b1, DW'(256+2), 4'd9), "interleave beat 3");
        apply(mk(OP_A, '0,   '0, '0, 1'b0, '0,         4'd8), "advance with no burst");
        apply(mk(OP_I, '0,   '0, '0, 1'b0, '0,         4'd8), "orphan advance idle");  // R8

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule